// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block sits on the device side of a parallel ATA host link. The host addresses eight byte-wide register slots with a 3-bit offset. The block holds the sector count, a 24-bit logical block address and the drive/head selection byte. A single command slot starts one of four operations: the device identity dump, a cache flush, a DMA read or a DMA write. Status is reported with the usual busy, ready, fault, data-request and error bits, and there is a level interrupt request.

The identity dump is served word by word through a 16-bit programmed-I/O data port from a table computed in logic. The table carries a serial string, a firmware string and a flag that shows the write cache as enabled. The backing store is not modelled. A flush is a request/acknowledge pair, and a DMA transfer is a start pulse with a direction, closed by a done strobe from the transfer engine.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, status (offset 7) reads 0x0040, offset 6 reads 0x0000, and irq_o, flush_req_o and dma_start_o are low.
- R2: Byte writes to offsets 2 (sector count), 3, 4 and 5 (LBA bits 7:0, 15:8, 23:16) read back the same value, with bits 15:8 of host_rdata_o zero.
- R3: Offset 6 reads back the value last written. Bit 6 selects LBA addressing and bit 4 selects device 1, so writing 0x40 reads back with bit 4 clear and writing 0x50 reads back with bit 4 set.
- R4: Command 0xEC sets status to 0x48 (DRDY and DRQ) and raises irq_o. Exactly 256 reads of offset 0 each return one word. Status reads 0x48 before each word and 0x40 after the last one. Offset 0 reads 0 when DRQ is clear.
- R5: Identity word 0 is 0x0040. Words 10 to 19 hold the 20-character serial string and words 23 to 26 hold the 8-character firmware string, in each case two characters per word with the earlier character in bits 15:8. Word 85 is 0x0020 (bit 5: write cache enabled). All other words are 0.
- R6: Command 0xE7 raises flush_req_o, and status reads 0xC0 (BSY and DRDY) until flush_done_i. The clock edge that samples flush_done_i drops flush_req_o, sets status to 0x40 and raises irq_o.
- R7: Commands 0xC8 and 0xCA pulse dma_start_o for exactly one cycle after the accepting edge. dma_dir_o is 1 for 0xC8 (device to memory) and 0 for 0xCA. Status reads 0xC0 until dma_done_i, then 0x40 with irq_o raised.
- R8: Any other command code sets status to 0x41 (DRDY and ERR) and raises irq_o. ERR clears when the next command is accepted.
- R9: A host read of offset 7 clears irq_o at that clock edge.
- R10: A command write while BSY or DRQ is set is ignored. State, status and handshake outputs are left as they were.
- R11: An accepted command write clears a pending interrupt, unless that command raises a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe (side effects at the edge) |
| host_addr_i | input | 3 | Register offset |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 16 | Read data for the offset on host_addr_i |
| irq_o | output | 1 | Interrupt request level |
| flush_req_o | output | 1 | Cache flush request to backing store |
| flush_done_i | input | 1 | Flush completion strobe |
| dma_start_o | output | 1 | One-cycle DMA start pulse |
| dma_dir_o | output | 1 | DMA direction, 1 = device to memory |
| dma_done_i | input | 1 | DMA completion strobe |

## Verification
The hardest case to reach is a command write that arrives while another command is still running, because the bench must hold the block inside a flush or part-way through the 256-word identity dump. The stimulus parks a flush by holding flush_done_i low, then issues an identify command. It then completes the flush and checks that status returns to plain ready, with no data request. In the same way, a flush command is written in the middle of the identity dump, and the bench checks that flush_req_o stays low and the dump's remaining words are still correct. A pending interrupt from a rejected code is cleared by the next good command, without any status read.

// File: rtl/ata_pkg.sv
package ata_pkg;
  localparam logic [2:0] OFF_DATA  = 3'd0;
  localparam logic [2:0] OFF_NSECT = 3'd2;
  localparam logic [2:0] OFF_LBA_LO = 3'd3;
  localparam logic [2:0] OFF_DEV   = 3'd6;
  localparam logic [2:0] OFF_CMD   = 3'd7;
  localparam int         LBA_BYTES = 3;

  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DF   = 5;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [7:0] CMD_RD_DMA = 8'hC8;
  localparam logic [7:0] CMD_WR_DMA = 8'hCA;
  localparam logic [7:0] CMD_FLUSH  = 8'hE7;
  localparam logic [7:0] CMD_IDENT  = 8'hEC;

  localparam int ID_SER_BASE   = 10;
  localparam int ID_FW_BASE    = 23;
  localparam int ID_CACHE_WORD = 85;
  localparam logic [15:0] ID_WORD0      = 16'h0040;
  localparam logic [15:0] ID_CACHE_FLAG = 16'h0020;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PIO   = 2'd1,
    SEQ_FLUSH = 2'd2,
    SEQ_DMA   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ata_regfile.sv
module ata_regfile
  import ata_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic [7:0] nsect_q;
  logic [7:0] dev_q;
  logic [7:0] lba_q [LBA_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nsect_q <= '0;
      dev_q   <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFF_NSECT) nsect_q <= wdata_i;
      if (addr_i == OFF_DEV)   dev_q   <= wdata_i;
    end
  end

  for (genvar g = 0; g < LBA_BYTES; g++) begin : g_lba
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        lba_q[g] <= '0;
      else if (wr_en_i && addr_i == OFF_LBA_LO + 3'(g))   lba_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_NSECT) rdata_o = nsect_q;
    if (addr_i == OFF_DEV)   rdata_o = dev_q;
    for (int i = 0; i < LBA_BYTES; i++)
      if (addr_i == OFF_LBA_LO + 3'(i)) rdata_o = lba_q[i];
  end
endmodule

// File: rtl/ata_ident_rom.sv
module ata_ident_rom
  import ata_pkg::*;
#(
  parameter int                    ID_WORDS  = 256,
  parameter int                    SER_CHARS = 20,
  parameter int                    FW_CHARS  = 8,
  parameter logic [SER_CHARS*8-1:0] SER_STR  = "SN0042              ",
  parameter logic [FW_CHARS*8-1:0]  FW_STR   = "FW1.00  ",
  localparam int                   IW        = $clog2(ID_WORDS)
) (
  input  logic [IW-1:0] idx_i,
  output logic [15:0]   word_o
);
  localparam int SER_WORDS = SER_CHARS / 2;
  localparam int FW_WORDS  = FW_CHARS / 2;
  localparam int SER_TOP   = SER_CHARS * 8 - 1;
  localparam int FW_TOP    = FW_CHARS * 8 - 1;

  always_comb begin
    word_o = '0;
    if (idx_i == IW'(0))             word_o = ID_WORD0;
    if (idx_i == IW'(ID_CACHE_WORD)) word_o = ID_CACHE_FLAG;
    for (int k = 0; k < SER_WORDS; k++)
      if (idx_i == IW'(ID_SER_BASE + k)) word_o = SER_STR[SER_TOP - 16*k -: 16];
    for (int k = 0; k < FW_WORDS; k++)
      if (idx_i == IW'(ID_FW_BASE + k))  word_o = FW_STR[FW_TOP - 16*k -: 16];
  end
endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
  import ata_pkg::*;
#(
  parameter int  ID_WORDS = 256,
  localparam int IW       = $clog2(ID_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic [7:0]    cmd_i,
  input  logic          status_rd_i,
  input  logic          data_rd_i,
  input  logic          flush_done_i,
  input  logic          dma_done_i,
  output logic [7:0]    status_o,
  output logic          irq_o,
  output logic [IW-1:0] idx_o,
  output logic          flush_req_o,
  output logic          dma_start_o,
  output logic          dma_dir_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(ID_WORDS - 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          err_q, err_d;
  logic          irq_q, irq_d;
  logic          start_q, start_d;
  logic          dir_q, dir_d;
  logic          irq_set, cmd_acc;

  assign cmd_acc = cmd_wr_i && (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    err_d   = err_q;
    start_d = 1'b0;
    dir_d   = dir_q;
    irq_set = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (cmd_acc) begin
        err_d = 1'b0;
        unique case (cmd_i)
          CMD_IDENT: begin state_d = SEQ_PIO; idx_d = '0; irq_set = 1'b1; end
          CMD_FLUSH:  state_d = SEQ_FLUSH;
          CMD_RD_DMA: begin state_d = SEQ_DMA; start_d = 1'b1; dir_d = 1'b1; end
          CMD_WR_DMA: begin state_d = SEQ_DMA; start_d = 1'b1; dir_d = 1'b0; end
          default:    begin err_d = 1'b1; irq_set = 1'b1; end
        endcase
      end
      SEQ_PIO: if (data_rd_i) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) state_d = SEQ_IDLE;
      end
      SEQ_FLUSH: if (flush_done_i) begin state_d = SEQ_IDLE; irq_set = 1'b1; end
      SEQ_DMA:   if (dma_done_i)   begin state_d = SEQ_IDLE; irq_set = 1'b1; end
      default: state_d = SEQ_IDLE;
    endcase
    // a new completion wins over a clear in the same cycle
    if (irq_set)                      irq_d = 1'b1;
    else if (status_rd_i || cmd_acc)  irq_d = 1'b0;
    else                              irq_d = irq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      dir_q   <= dir_d;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_BSY]  = (state_q == SEQ_FLUSH) || (state_q == SEQ_DMA);
    status_o[ST_DRDY] = 1'b1;
    status_o[ST_DF]   = 1'b0;
    status_o[ST_DRQ]  = (state_q == SEQ_PIO);
    status_o[ST_ERR]  = err_q;
  end

  assign irq_o       = irq_q;
  assign idx_o       = idx_q;
  assign flush_req_o = (state_q == SEQ_FLUSH);
  assign dma_start_o = start_q;
  assign dma_dir_o   = dir_q;
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_pkg::*;
#(
  parameter int                     ID_WORDS  = 256,
  parameter int                     SER_CHARS = 20,
  parameter int                     FW_CHARS  = 8,
  parameter logic [SER_CHARS*8-1:0] SER_STR   = "SN0042              ",
  parameter logic [FW_CHARS*8-1:0]  FW_STR    = "FW1.00  "
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_wr_i,
  input  logic        host_rd_i,
  input  logic [2:0]  host_addr_i,
  input  logic [7:0]  host_wdata_i,
  output logic [15:0] host_rdata_o,
  output logic        irq_o,
  output logic        flush_req_o,
  input  logic        flush_done_i,
  output logic        dma_start_o,
  output logic        dma_dir_o,
  input  logic        dma_done_i
);
  localparam int IW = $clog2(ID_WORDS);

  logic [7:0]    reg_rdata;
  logic [7:0]    status_w;
  logic [IW-1:0] idx_w;
  logic [15:0]   id_word;
  logic          cmd_wr, status_rd, data_rd;

  assign cmd_wr    = host_wr_i && (host_addr_i == OFF_CMD);
  assign status_rd = host_rd_i && (host_addr_i == OFF_CMD);
  assign data_rd   = host_rd_i && (host_addr_i == OFF_DATA) && status_w[ST_DRQ];

  ata_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (host_wr_i),
    .addr_i  (host_addr_i),
    .wdata_i (host_wdata_i),
    .rdata_o (reg_rdata)
  );

  ata_cmd_seq #(.ID_WORDS(ID_WORDS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (cmd_wr),
    .cmd_i        (host_wdata_i),
    .status_rd_i  (status_rd),
    .data_rd_i    (data_rd),
    .flush_done_i (flush_done_i),
    .dma_done_i   (dma_done_i),
    .status_o     (status_w),
    .irq_o        (irq_o),
    .idx_o        (idx_w),
    .flush_req_o  (flush_req_o),
    .dma_start_o  (dma_start_o),
    .dma_dir_o    (dma_dir_o)
  );

  ata_ident_rom #(
    .ID_WORDS (ID_WORDS),
    .SER_CHARS(SER_CHARS),
    .FW_CHARS (FW_CHARS),
    .SER_STR  (SER_STR),
    .FW_STR   (FW_STR)
  ) u_rom (
    .idx_i  (idx_w),
    .word_o (id_word)
  );

  always_comb begin
    if (host_addr_i == OFF_CMD)       host_rdata_o = {8'h00, status_w};
    else if (host_addr_i == OFF_DATA) host_rdata_o = status_w[ST_DRQ] ? id_word : 16'h0000;
    else                              host_rdata_o = {8'h00, reg_rdata};
  end
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_rd_i,
  input logic       host_wr_i,
  input logic [2:0] host_addr_i,
  input logic       flush_done_i,
  input logic       dma_done_i,
  input logic       irq_o,
  input logic       flush_req_o,
  input logic       dma_start_o,
  input logic [7:0] status_w
);
  // R4
  bsy_drq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_w[7] && status_w[3]));

  // R6
  flush_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> (status_w[7] && status_w[6] && !status_w[3]));

  // R6
  flush_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && flush_done_i) |=> !flush_req_o);

  // R7
  dma_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start_o |=> !dma_start_o);

  // R9
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_addr_i == 3'd7 && !host_wr_i && !flush_done_i && !dma_done_i)
      |=> !irq_o);
endmodule

bind ata_taskfile_ctrl ata_taskfile_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_rd_i    (host_rd_i),
  .host_wr_i    (host_wr_i),
  .host_addr_i  (host_addr_i),
  .flush_done_i (flush_done_i),
  .dma_done_i   (dma_done_i),
  .irq_o        (irq_o),
  .flush_req_o  (flush_req_o),
  .dma_start_o  (dma_start_o),
  .status_w     (status_w)
);

// File: tb/tb_ata_taskfile_ctrl.sv
module tb_ata_taskfile_ctrl;
  localparam string SER = "SN0042              ";
  localparam string FW  = "FW1.00  ";
  localparam int SRC_RD = 0, SRC_IRQ = 1, SRC_FLUSH = 2, SRC_START = 3, SRC_DIR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic irq, flush_req, dma_start, dma_dir;
  logic flush_done = 1'b0, dma_done = 1'b0;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int   q_src[$];
  logic [15:0] q_exp[$];
  string q_tag[$];
  event sample_ev;

  always #10 clk = ~clk;

  ata_taskfile_ctrl #(
    .SER_STR("SN0042              "),
    .FW_STR ("FW1.00  ")
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_rd_i(host_rd),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .irq_o(irq), .flush_req_o(flush_req), .flush_done_i(flush_done),
    .dma_start_o(dma_start), .dma_dir_o(dma_dir), .dma_done_i(dma_done)
  );

  // monitor: pops expected items and compares against the live outputs
  task automatic drain();
    while (q_src.size() > 0) begin
      int s = q_src.pop_front();
      logic [15:0] e = q_exp.pop_front();
      string t = q_tag.pop_front();
      logic [15:0] a;
      case (s)
        SRC_RD:    a = host_rdata;
        SRC_IRQ:   a = {15'd0, irq};
        SRC_FLUSH: a = {15'd0, flush_req};
        SRC_START: a = {15'd0, dma_start};
        default:   a = {15'd0, dma_dir};
      endcase
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  endtask

  initial forever begin
    @(sample_ev);
    drain();
  end

  task automatic push(input int s, input logic [15:0] e, input string t);
    q_src.push_back(s); q_exp.push_back(e); q_tag.push_back(t);
    -> sample_ev;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string t);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #2 push(SRC_RD, e, t);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic sig_chk(input int s, input logic e, input string t);
    #1 push(s, {15'd0, e}, t);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush_done = 1'b1;
    @(negedge clk); flush_done = 1'b0;
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
  endtask

  function automatic logic [15:0] id_exp(input int i);
    if (i == 0) return 16'h0040;
    if (i == 85) return 16'h0020;
    if (i >= 10 && i < 20) return {SER[2*(i-10)], SER[2*(i-10)+1]};
    if (i >= 23 && i < 27) return {FW[2*(i-23)], FW[2*(i-23)+1]};
    return 16'h0000;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      drain();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    sig_chk(SRC_IRQ, 1'b0, "R1 irq");
    sig_chk(SRC_FLUSH, 1'b0, "R1 flush_req");
    sig_chk(SRC_START, 1'b0, "R1 dma_start");
    rd_chk(3'd7, 16'h0040, "R1 status");
    rd_chk(3'd6, 16'h0000, "R1 device");

    // R2 byte registers
    wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56); wr(3'd5, 8'h78);
    rd_chk(3'd2, 16'h0012, "R2 nsect");
    rd_chk(3'd3, 16'h0034, "R2 lba_lo");
    rd_chk(3'd4, 16'h0056, "R2 lba_mid");
    rd_chk(3'd5, 16'h0078, "R2 lba_hi");
    wr(3'd5, 8'hFF);
    rd_chk(3'd5, 16'h00FF, "R2 lba_hi upper byte zero");

    // R3 device selection
    wr(3'd6, 8'h50);
    rd_chk(3'd6, 16'h0050, "R3 dev1 bit4 set");
    wr(3'd6, 8'h40);
    rd_chk(3'd6, 16'h0040, "R3 dev0 bit4 clear");

    // R4 R5 identity dump
    wr(3'd7, 8'hEC);
    sig_chk(SRC_IRQ, 1'b1, "R4 irq on block ready");
    for (int i = 0; i < 256; i++) begin
      rd_chk(3'd7, 16'h0048, "R4 status before word");
      if (i == 0) sig_chk(SRC_IRQ, 1'b0, "R9 status read clears irq");
      if (i == 100) begin
        wr(3'd7, 8'hE7);
        sig_chk(SRC_FLUSH, 1'b0, "R10 flush ignored during PIO");
      end
      rd_chk(3'd0, id_exp(i), "R5 identity word");
    end
    rd_chk(3'd7, 16'h0040, "R4 DRQ clear after last word");
    rd_chk(3'd0, 16'h0000, "R4 data zero without DRQ");

    // R6 flush, with R10 command during busy
    wr(3'd7, 8'hE7);
    sig_chk(SRC_FLUSH, 1'b1, "R6 flush_req raised");
    rd_chk(3'd7, 16'h00C0, "R6 status busy");
    repeat (3) @(negedge clk);
    wr(3'd7, 8'hEC);
    rd_chk(3'd7, 16'h00C0, "R10 status unchanged");
    sig_chk(SRC_FLUSH, 1'b1, "R10 flush_req held");
    pulse_flush();
    sig_chk(SRC_IRQ, 1'b1, "R6 irq on completion");
    sig_chk(SRC_FLUSH, 1'b0, "R6 flush_req dropped");
    rd_chk(3'd7, 16'h0040, "R6 R10 ready no DRQ");
    sig_chk(SRC_IRQ, 1'b0, "R9 irq cleared");

    // R7 read DMA
    wr(3'd7, 8'hC8);
    sig_chk(SRC_START, 1'b1, "R7 start pulse");
    sig_chk(SRC_DIR, 1'b1, "R7 dir read");
    @(negedge clk);
    sig_chk(SRC_START, 1'b0, "R7 start one cycle");
    rd_chk(3'd7, 16'h00C0, "R7 busy");
    pulse_dma();
    sig_chk(SRC_IRQ, 1'b1, "R7 irq on done");
    rd_chk(3'd7, 16'h0040, "R7 ready");

    // R7 write DMA
    wr(3'd7, 8'hCA);
    sig_chk(SRC_START, 1'b1, "R7 start pulse wr");
    sig_chk(SRC_DIR, 1'b0, "R7 dir write");
    repeat (4) @(negedge clk);
    rd_chk(3'd7, 16'h00C0, "R7 busy wr");
    pulse_dma();
    rd_chk(3'd7, 16'h0040, "R7 ready wr");

    // R8 unknown command
    wr(3'd7, 8'h90);
    sig_chk(SRC_IRQ, 1'b1, "R8 irq");
    rd_chk(3'd7, 16'h0041, "R8 err status");

    // R11 accepted command clears pending irq, ERR cleared
    wr(3'd7, 8'h33);
    sig_chk(SRC_IRQ, 1'b1, "R11 irq pending");
    wr(3'd7, 8'hC8);
    sig_chk(SRC_IRQ, 1'b0, "R11 irq cleared by command");
    rd_chk(3'd7, 16'h00C0, "R8 err cleared by next command");
    pulse_dma();
    rd_chk(3'd7, 16'h0040, "R8 final ready");

    #5;
    summary();
  end
endmodule